// File: doc/BRIEF.md
# Command Transfer Engine

This block moves one command and its response between a host register port and a command-processing backend. The host writes the command as a byte stream through a data FIFO register. The engine reads the total command length from the command header, tracks how many bytes are still expected, and starts the backend when the host issues a go request. When the backend signals that it is done, the host reads the response back through the same FIFO register. A status register reports the engine flags and a burst count. The burst count tells the host how many bytes it may move next.

Command and response share one byte buffer of `DEPTH` entries. The backend reads the command and writes the response through its own port while the engine is executing. Host accesses take effect only while the `owner` input is high. Deciding who owns the interface, and executing the command, are the job of neighbouring blocks. Three one-cycle event outputs (command ready, status valid, data available) feed an interrupt controller placed elsewhere.

Top module: `cmd_xfer_engine`

## Requirements
- R1: After reset the engine is idle and all flags are clear. A 4-byte status read returns 0x00100000 (full free space, DEPTH=4096). `reg_rvalid` is low while no read is requested.
- R2: A status write whose only request bit is command-ready (bit 6) works as follows. In idle it moves to ready, sets the command-ready flag (bit 6) and pulses `ev_cmd_ready`. In ready it only zeroes both offsets and raises no event.
- R3: The first FIFO write (`reg_sel`=1) in ready moves to reception. It sets the more-expected flag (bit 3) and the valid flag (bit 7), and clears command-ready. FIFO writes in idle, execution or completion are dropped.
- R4: Command byte k of a write word sits at bits 8k+7..8k. The header length is the 32-bit big-endian value in command bytes 2..5. It is checked once more than 5 bytes are held. The more-expected flag stays set while that length exceeds the byte count and clears once the two are equal. FIFO writes after that are dropped.
- R5: A status write whose only request bit is go (bit 5) starts the command when the engine is in reception with more-expected clear. Starting means moving to execution and pulsing `be_start`, with `be_cmd_len` equal to the bytes received. Go is ignored while more-expected is set. The backend reads command byte i at `be_raddr`=i.
- R6: `be_done` in execution moves to completion. It sets valid and data-available (bit 4), zeroes both offsets, and pulses `ev_data_avail` and `ev_sts_valid` together.
- R7: The burst count sits in status bits 23..8. While data is available it equals the response length minus the read offset. Otherwise it equals DEPTH minus the write offset, capped at 0xFF when `reg_size` is 1.
- R8: FIFO reads in completion with data available return response bytes in order. The response length is bytes 2..5 of the response, big-endian. Reading the last byte clears data-available and pulses `ev_sts_valid`. Any requested byte with no response data behind it reads 0xFF.
- R9: A status write whose only request bit is retry (bit 1), in completion, rewinds the read offset to 0 and sets valid and data-available again.
- R10: Command-ready in completion zeroes both offsets and moves to ready. It sets command-ready with an `ev_cmd_ready` pulse and clears data-available.
- R11: A FIFO access of `reg_size` bytes at byte lane `reg_lane` is clipped to 4 minus `reg_lane` bytes. Requested lanes that are not transferred read as 0x00.
- R12: While `owner` is low, every read returns 0xFFFFFFFF and every write is ignored.
- R13: Read data appears on `reg_rdata` in the cycle after the read request, with `reg_rvalid` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| owner | input | 1 | High while the host side owns the interface |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored when reg_wr is high) |
| reg_sel | input | 1 | 0 = status register, 1 = data FIFO |
| reg_size | input | 3 | Access size in bytes, 1 to 4 |
| reg_lane | input | 2 | Starting byte lane inside the 32-bit word |
| reg_wdata | input | 32 | Write data, byte k in bits 8k+7..8k |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid |
| ev_cmd_ready | output | 1 | Command-ready event pulse |
| ev_sts_valid | output | 1 | Status-valid event pulse |
| ev_data_avail | output | 1 | Data-available event pulse |
| be_start | output | 1 | One-cycle start of backend execution |
| be_cmd_len | output | AW+1 | Command length in bytes |
| be_raddr | input | AW | Backend read address into the buffer |
| be_rdata | output | 8 | Buffer byte at be_raddr |
| be_we | input | 1 | Backend response byte write (honoured in execution) |
| be_waddr | input | AW | Backend write address |
| be_wdata | input | 8 | Backend write byte |
| be_done | input | 1 | Backend finished, response in buffer |

## Verification
The main flow runs a 10-byte command in three write shapes: a full word, a word that leaves the header length short, and a 2-byte tail that completes it. This separates a length taken from the header from a flag that clears at the first word. A 7-byte response is read as a full word and then a partial word that runs past its end, which shows whether the last-byte detection and the 0xFF padding fall on the right lane. Retry and then a lane-offset read confirm that the rewind and the word clipping move the read offset by the clipped count only. Writes in idle, execution and after completion, as well as accesses by a non-owner, are each followed by a status read that would reveal any change.

// File: rtl/cxe_pkg.sv
package cxe_pkg;

  typedef enum logic [2:0] {
    CX_IDLE  = 3'd0,
    CX_READY = 3'd1,
    CX_RECV  = 3'd2,
    CX_EXEC  = 3'd3,
    CX_CMPL  = 3'd4
  } cx_state_e;

  // request bit positions inside a status write
  localparam int FB_CMDRDY = 6;
  localparam int FB_GO     = 5;
  localparam int FB_RETRY  = 1;

  localparam logic [7:0] NO_DATA_BYTE = 8'hFF;

  // place a header byte into a big-endian 32-bit length held in bytes 2..5
  function automatic logic [31:0] hdr_len_merge(input logic [31:0] cur,
                                                input logic [31:0] idx,
                                                input logic [7:0]  b);
    logic [31:0] r;
    r = cur;
    if (idx == 32'd2) r[31:24] = b;
    else if (idx == 32'd3) r[23:16] = b;
    else if (idx == 32'd4) r[15:8] = b;
    else if (idx == 32'd5) r[7:0] = b;
    return r;
  endfunction

  // bytes the host may move next
  function automatic logic [15:0] burst_calc(input logic        avail,
                                             input logic [31:0] rsp_len,
                                             input logic [31:0] r_off,
                                             input logic [31:0] depth,
                                             input logic [31:0] w_off,
                                             input logic        single);
    logic [31:0] v;
    if (avail) begin
      v = rsp_len - r_off;
    end else begin
      v = depth - w_off;
      if (single && v > 32'd255) v = 32'd255;
    end
    return v[15:0];
  endfunction

  function automatic logic [31:0] status_word(input logic [15:0] burst,
                                              input logic valid,
                                              input logic cmdrdy,
                                              input logic avail,
                                              input logic more);
    return {8'h00, burst, valid, cmdrdy, 1'b0, avail, more, 3'b000};
  endfunction

endpackage

// File: rtl/cxe_buf.sv
module cxe_buf #(
  parameter int DEPTH = 4096,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [3:0]    h_we,
  input  logic [AW-1:0] h_base,
  input  logic [31:0]   h_wdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_waddr,
  input  logic [7:0]    b_wdata,
  input  logic [AW-1:0] r_base,
  output logic [31:0]   r_data,
  input  logic [AW-1:0] b_raddr,
  output logic [7:0]    b_rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (h_we[k]) mem[h_base + AW'(k)] <= h_wdata[8*k +: 8];
    end
    if (b_we) mem[b_waddr] <= b_wdata;
  end

  generate
    for (genvar g = 0; g < 4; g++) begin : g_rd_lane
      assign r_data[8*g +: 8] = mem[r_base + AW'(g)];
    end
  endgenerate

  assign b_rdata = mem[b_raddr];

endmodule

// File: rtl/cxe_lane_ctl.sv
module cxe_lane_ctl #(
  parameter int DEPTH = 4096,
  parameter int CW = $clog2(DEPTH) + 1
) (
  input  logic [2:0]    acc_size,
  input  logic [1:0]    acc_lane,
  input  logic [CW-1:0] w_off,
  input  logic [CW-1:0] r_off,
  input  logic [CW-1:0] rsp_len,
  input  logic          rd_live,
  output logic [2:0]    n_bytes,
  output logic [3:0]    wr_mask,
  output logic [2:0]    wr_cnt,
  output logic [2:0]    rd_take
);

  logic [2:0]    room;
  logic [CW-1:0] remain;

  // clip the access so it stays inside the 32-bit word
  always_comb begin
    room    = 3'd4 - {1'b0, acc_lane};
    n_bytes = (acc_size > room) ? room : acc_size;
  end

  // write lanes that still have buffer space behind them
  always_comb begin
    wr_cnt = 3'd0;
    for (int k = 0; k < 4; k++) begin
      wr_mask[k] = (3'(k) < n_bytes) && ((32'(w_off) + 32'(k)) < 32'(DEPTH));
      wr_cnt     = wr_cnt + {2'b00, wr_mask[k]};
    end
  end

  // response bytes a read may take; at least one while data is live
  always_comb begin
    remain = (rsp_len > r_off) ? (rsp_len - r_off) : CW'(1);
    if (!rd_live) rd_take = 3'd0;
    else if ({{(CW-3){1'b0}}, n_bytes} <= remain) rd_take = n_bytes;
    else rd_take = remain[2:0];
  end

endmodule

// File: rtl/cmd_xfer_engine.sv
module cmd_xfer_engine
  import cxe_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          owner,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_sel,
  input  logic [2:0]    reg_size,
  input  logic [1:0]    reg_lane,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  output logic          ev_cmd_ready,
  output logic          ev_sts_valid,
  output logic          ev_data_avail,
  output logic          be_start,
  output logic [CW-1:0] be_cmd_len,
  input  logic [AW-1:0] be_raddr,
  output logic [7:0]    be_rdata,
  input  logic          be_we,
  input  logic [AW-1:0] be_waddr,
  input  logic [7:0]    be_wdata,
  input  logic          be_done
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  cx_state_e     st_q, st_d;
  logic [CW-1:0] woff_q, woff_d, roff_q, roff_d;
  logic [31:0]   clen_q, clen_d, rlen_q, rlen_d;
  logic          fv_q, fv_d, fc_q, fc_d, fa_q, fa_d, fm_q, fm_d;
  logic [31:0]   rdata_d;
  logic          rvalid_d, evc_d, evs_d, eva_d, start_d;

  // access decode, brought out as named wires
  logic sts_wr, fifo_wr, fifo_rd, any_rd;
  logic req_rdy, req_go, req_retry;
  assign sts_wr    = reg_wr && owner && !reg_sel;
  assign fifo_wr   = reg_wr && owner && reg_sel;
  assign any_rd    = reg_rd && !reg_wr;
  assign fifo_rd   = any_rd && owner && reg_sel;
  assign req_rdy   = reg_wdata[FB_CMDRDY] && !reg_wdata[FB_GO] && !reg_wdata[FB_RETRY];
  assign req_go    = !reg_wdata[FB_CMDRDY] && reg_wdata[FB_GO] && !reg_wdata[FB_RETRY];
  assign req_retry = !reg_wdata[FB_CMDRDY] && !reg_wdata[FB_GO] && reg_wdata[FB_RETRY];

  logic [CW-1:0] rlen_eff;
  assign rlen_eff = (rlen_q > 32'(DEPTH)) ? DEPTH_C : rlen_q[CW-1:0];

  logic       rd_live;
  logic [2:0] n_bytes, wr_cnt, rd_take;
  logic [3:0] wr_mask;
  assign rd_live = (st_q == CX_CMPL) && fa_q;

  cxe_lane_ctl #(.DEPTH(DEPTH), .CW(CW)) u_lane (
    .acc_size (reg_size),
    .acc_lane (reg_lane),
    .w_off    (woff_q),
    .r_off    (roff_q),
    .rsp_len  (rlen_eff),
    .rd_live  (rd_live),
    .n_bytes  (n_bytes),
    .wr_mask  (wr_mask),
    .wr_cnt   (wr_cnt),
    .rd_take  (rd_take)
  );

  // command bytes are stored while ready, or while more are expected
  logic          store_ok;
  logic [3:0]    h_we;
  logic [CW-1:0] woff_after;
  logic [31:0]   clen_nx;
  logic          bew_ok;
  logic [31:0]   buf_rd;

  assign store_ok   = (st_q == CX_READY) || ((st_q == CX_RECV) && fm_q);
  assign h_we       = wr_mask & {4{fifo_wr && store_ok}};
  assign woff_after = woff_q + CW'(wr_cnt);
  assign bew_ok     = be_we && (st_q == CX_EXEC);

  always_comb begin
    clen_nx = clen_q;
    for (int k = 0; k < 4; k++) begin
      if (h_we[k]) clen_nx = hdr_len_merge(clen_nx, 32'(woff_q) + 32'(k), reg_wdata[8*k +: 8]);
    end
  end

  cxe_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk     (clk),
    .h_we    (h_we),
    .h_base  (woff_q[AW-1:0]),
    .h_wdata (reg_wdata),
    .b_we    (bew_ok),
    .b_waddr (be_waddr),
    .b_wdata (be_wdata),
    .r_base  (roff_q[AW-1:0]),
    .r_data  (buf_rd),
    .b_raddr (be_raddr),
    .b_rdata (be_rdata)
  );

  // read data path
  always_comb begin
    rdata_d  = '1;
    rvalid_d = any_rd;
    if (owner && any_rd) begin
      if (!reg_sel) begin
        rdata_d = status_word(burst_calc(fa_q, 32'(rlen_eff), 32'(roff_q), 32'(DEPTH),
                                         32'(woff_q), reg_size == 3'd1),
                              fv_q, fc_q, fa_q, fm_q);
      end else begin
        rdata_d = '0;
        for (int k = 0; k < 4; k++) begin
          if (3'(k) < n_bytes)
            rdata_d[8*k +: 8] = (3'(k) < rd_take) ? buf_rd[8*k +: 8] : NO_DATA_BYTE;
        end
      end
    end
  end

  // state, offsets and flags
  always_comb begin
    st_d    = st_q;
    woff_d  = woff_q;
    roff_d  = roff_q;
    clen_d  = clen_q;
    rlen_d  = rlen_q;
    fv_d    = fv_q;
    fc_d    = fc_q;
    fa_d    = fa_q;
    fm_d    = fm_q;
    evc_d   = 1'b0;
    evs_d   = 1'b0;
    eva_d   = 1'b0;
    start_d = 1'b0;

    if (sts_wr) begin
      if (req_rdy) begin
        unique case (st_q)
          CX_IDLE: begin
            st_d  = CX_READY;
            fv_d  = 1'b0;
            fc_d  = 1'b1;
            fa_d  = 1'b0;
            fm_d  = 1'b0;
            evc_d = 1'b1;
          end
          CX_READY: begin
            woff_d = '0;
            roff_d = '0;
          end
          CX_CMPL: begin
            woff_d = '0;
            roff_d = '0;
            st_d   = CX_READY;
            if (!fc_q) begin
              fv_d  = 1'b0;
              fc_d  = 1'b1;
              fm_d  = 1'b0;
              evc_d = 1'b1;
            end
            fa_d = 1'b0;
          end
          default: ;
        endcase
      end else if (req_go) begin
        if (st_q == CX_RECV && !fm_q) begin
          st_d    = CX_EXEC;
          start_d = 1'b1;
          rlen_d  = '0;
        end
      end else if (req_retry) begin
        if (st_q == CX_CMPL) begin
          roff_d = '0;
          fv_d   = 1'b1;
          fa_d   = 1'b1;
          fc_d   = 1'b0;
          fm_d   = 1'b0;
        end
      end
    end else if (fifo_wr) begin
      if (store_ok) begin
        if (st_q == CX_READY) begin
          st_d = CX_RECV;
          fv_d = 1'b1;
          fm_d = 1'b1;
          fc_d = 1'b0;
          fa_d = 1'b0;
        end
        woff_d = woff_after;
        clen_d = clen_nx;
        if (woff_after > CW'(5)) begin
          fv_d = 1'b1;
          fm_d = clen_nx > 32'(woff_after);
        end
      end
    end else if (fifo_rd) begin
      if (rd_take != 3'd0) begin
        roff_d = roff_q + CW'(rd_take);
        if (roff_d >= rlen_eff) begin
          fv_d  = 1'b1;
          fc_d  = 1'b0;
          fa_d  = 1'b0;
          fm_d  = 1'b0;
          evs_d = 1'b1;
        end
      end
    end

    if (st_q == CX_EXEC) begin
      if (bew_ok) rlen_d = hdr_len_merge(rlen_d, 32'(be_waddr), be_wdata);
      if (be_done) begin
        st_d   = CX_CMPL;
        fv_d   = 1'b1;
        fa_d   = 1'b1;
        fc_d   = 1'b0;
        fm_d   = 1'b0;
        woff_d = '0;
        roff_d = '0;
        eva_d  = 1'b1;
        evs_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= CX_IDLE;
      woff_q        <= '0;
      roff_q        <= '0;
      clen_q        <= '0;
      rlen_q        <= '0;
      fv_q          <= 1'b0;
      fc_q          <= 1'b0;
      fa_q          <= 1'b0;
      fm_q          <= 1'b0;
      reg_rdata     <= '0;
      reg_rvalid    <= 1'b0;
      ev_cmd_ready  <= 1'b0;
      ev_sts_valid  <= 1'b0;
      ev_data_avail <= 1'b0;
      be_start      <= 1'b0;
    end else begin
      st_q          <= st_d;
      woff_q        <= woff_d;
      roff_q        <= roff_d;
      clen_q        <= clen_d;
      rlen_q        <= rlen_d;
      fv_q          <= fv_d;
      fc_q          <= fc_d;
      fa_q          <= fa_d;
      fm_q          <= fm_d;
      reg_rdata     <= rvalid_d ? rdata_d : reg_rdata;
      reg_rvalid    <= rvalid_d;
      ev_cmd_ready  <= evc_d;
      ev_sts_valid  <= evs_d;
      ev_data_avail <= eva_d;
      be_start      <= start_d;
    end
  end

  assign be_cmd_len = woff_q;

  // ---------------- assertions ----------------
  p_cmdrdy_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_ready |-> (fc_q && st_q == CX_READY));

  p_more_only_recv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fm_q |-> (st_q == CX_RECV));

  p_start_from_recv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> (st_q == CX_EXEC && $past(st_q) == CX_RECV));

  p_avail_only_cmpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fa_q |-> (st_q == CX_CMPL));

  p_done_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_avail |-> (fa_q && roff_q == '0 && woff_q == '0 && ev_sts_valid));

  p_woff_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    woff_q <= DEPTH_C);

  p_last_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sts_valid && !ev_data_avail) |-> !fa_q);

  p_word_clip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (32'(n_bytes) + 32'(reg_lane) <= 32'd4));

  p_read_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> reg_rvalid);

endmodule

// File: tb/cmd_xfer_engine_test.sv
module cmd_xfer_engine_test;

  localparam int DEPTH = 4096;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          owner = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic          reg_sel = 1'b0;
  logic [2:0]    reg_size = 3'd4;
  logic [1:0]    reg_lane = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_rvalid;
  logic          ev_cmd_ready, ev_sts_valid, ev_data_avail;
  logic          be_start;
  logic [CW-1:0] be_cmd_len;
  logic [AW-1:0] be_raddr = '0;
  logic [7:0]    be_rdata;
  logic          be_we = 1'b0;
  logic [AW-1:0] be_waddr = '0;
  logic [7:0]    be_wdata = '0;
  logic          be_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic cap_c, cap_s, cap_a, cap_start, cap_rv;
  logic [31:0] rd_val;

  always #4 clk = ~clk;

  cmd_xfer_engine #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .owner(owner),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_size(reg_size), .reg_lane(reg_lane), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .ev_cmd_ready(ev_cmd_ready), .ev_sts_valid(ev_sts_valid), .ev_data_avail(ev_data_avail),
    .be_start(be_start), .be_cmd_len(be_cmd_len),
    .be_raddr(be_raddr), .be_rdata(be_rdata),
    .be_we(be_we), .be_waddr(be_waddr), .be_wdata(be_wdata), .be_done(be_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data, input logic [2:0] size,
                    input logic [1:0] lane);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data; reg_size = size; reg_lane = lane;
    @(negedge clk);
    cap_c = ev_cmd_ready; cap_s = ev_sts_valid; cap_a = ev_data_avail; cap_start = be_start;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [2:0] size, input logic [1:0] lane);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel; reg_size = size; reg_lane = lane;
    @(negedge clk);
    rd_val = reg_rdata; cap_rv = reg_rvalid;
    cap_c = ev_cmd_ready; cap_s = ev_sts_valid; cap_a = ev_data_avail;
    reg_rd = 1'b0;
  endtask

  task automatic sts(input string req, input logic [31:0] exp);
    rd(1'b0, 3'd4, 2'd0);
    chk(req, rd_val, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rvalid idle", {31'd0, reg_rvalid}, 32'd0);
    sts("R1 status after reset", 32'h0010_0000);
    chk("R13 rvalid with read", {31'd0, cap_rv}, 32'd1);
    rd(1'b0, 3'd1, 2'd0);
    chk("R7 single-byte burst cap", rd_val, 32'h0000_FF00);
  endtask

  task automatic t_idle_traffic;
    wr(1'b1, 32'h1234_5678, 3'd4, 2'd0);
    sts("R3 idle write dropped", 32'h0010_0000);
    rd(1'b1, 3'd4, 2'd0);
    chk("R8 no-data word", rd_val, 32'hFFFF_FFFF);
    rd(1'b1, 3'd2, 2'd0);
    chk("R11 no-data two bytes", rd_val, 32'h0000_FFFF);
  endtask

  task automatic t_owner;
    owner = 1'b0;
    sts("R12 non-owner read", 32'hFFFF_FFFF);
    wr(1'b0, 32'h0000_0040, 3'd4, 2'd0);
    chk("R12 non-owner write no event", {31'd0, cap_c}, 32'd0);
    owner = 1'b1;
    sts("R12 state untouched", 32'h0010_0000);
  endtask

  task automatic t_cmd_ready;
    wr(1'b0, 32'h0000_0040, 3'd4, 2'd0);
    chk("R2 cmd-ready event", {31'd0, cap_c}, 32'd1);
    sts("R2 ready status", 32'h0010_0040);
    wr(1'b0, 32'h0000_0040, 3'd4, 2'd0);
    chk("R2 no event in ready", {31'd0, cap_c}, 32'd0);
    sts("R2 ready unchanged", 32'h0010_0040);
  endtask

  task automatic t_send;
    wr(1'b1, 32'h0000_0180, 3'd4, 2'd0);
    sts("R3 reception flags", 32'h000F_FC88);
    rd(1'b0, 3'd1, 2'd0);
    chk("R7 single-byte cap in reception", rd_val, 32'h0000_FF88);
    wr(1'b1, 32'h2211_0A00, 3'd4, 2'd0);
    sts("R4 still expecting", 32'h000F_F888);
    wr(1'b0, 32'h0000_0020, 3'd4, 2'd0);
    chk("R5 go ignored while expecting", {31'd0, cap_start}, 32'd0);
    sts("R5 go ignored status", 32'h000F_F888);
    wr(1'b1, 32'h0000_4433, 3'd2, 2'd0);
    sts("R4 packet complete", 32'h000F_F680);
    wr(1'b1, 32'h0000_0099, 3'd1, 2'd0);
    sts("R4 extra byte dropped", 32'h000F_F680);
    wr(1'b0, 32'h0000_0020, 3'd4, 2'd0);
    chk("R5 start pulse", {31'd0, cap_start}, 32'd1);
    chk("R5 command length", 32'(be_cmd_len), 32'd10);
    wr(1'b1, 32'h0000_0055, 3'd1, 2'd0);
    sts("R3 execution write dropped", 32'h000F_F680);
  endtask

  task automatic t_backend;
    logic [7:0] rsp [7];
    rsp[0] = 8'hC4; rsp[1] = 8'h00; rsp[2] = 8'h00; rsp[3] = 8'h00;
    rsp[4] = 8'h00; rsp[5] = 8'h07; rsp[6] = 8'hAB;
    @(negedge clk);
    be_raddr = AW'(5);
    #1 chk("R5 backend reads length byte", {24'd0, be_rdata}, 32'h0000_000A);
    be_raddr = AW'(7);
    #1 chk("R5 backend reads payload byte", {24'd0, be_rdata}, 32'h0000_0022);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      be_we = 1'b1; be_waddr = AW'(i); be_wdata = rsp[i];
    end
    @(negedge clk);
    be_we = 1'b0; be_done = 1'b1;
    @(negedge clk);
    chk("R6 data-avail event", {31'd0, ev_data_avail}, 32'd1);
    chk("R6 status-valid event", {31'd0, ev_sts_valid}, 32'd1);
    be_done = 1'b0;
    sts("R6 completion status", 32'h0000_0790);
  endtask

  task automatic t_readout;
    rd(1'b1, 3'd4, 2'd0);
    chk("R8 first word", rd_val, 32'h0000_00C4);
    chk("R13 rvalid on fifo read", {31'd0, cap_rv}, 32'd1);
    sts("R7 burst after 4", 32'h0000_0390);
    rd(1'b1, 3'd4, 2'd0);
    chk("R8 tail word padded", rd_val, 32'hFFAB_0700);
    chk("R8 last byte event", {31'd0, cap_s}, 32'd1);
    sts("R8 avail cleared", 32'h0010_0080);
    rd(1'b1, 3'd4, 2'd0);
    chk("R8 read past end", rd_val, 32'hFFFF_FFFF);
  endtask

  task automatic t_retry;
    wr(1'b0, 32'h0000_0002, 3'd4, 2'd0);
    sts("R9 retry status", 32'h0000_0790);
    rd(1'b1, 3'd1, 2'd0);
    chk("R9 first byte again", rd_val, 32'h0000_00C4);
    rd(1'b1, 3'd4, 2'd2);
    chk("R11 clipped read", rd_val, 32'h0000_0000);
    sts("R11 offset moved by clip", 32'h0000_0490);
  endtask

  task automatic t_back_to_ready;
    wr(1'b0, 32'h0000_0040, 3'd4, 2'd0);
    chk("R10 cmd-ready event", {31'd0, cap_c}, 32'd1);
    sts("R10 ready status", 32'h0010_0040);
    wr(1'b1, 32'h0000_00AA, 3'd4, 2'd3);
    sts("R11 clipped write one byte", 32'h000F_FF88);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_traffic();
    t_owner();
    t_cmd_ready();
    t_send();
    t_backend();
    t_readout();
    t_retry();
    t_back_to_ready();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule